// File: doc/BRIEF.md
# Strand Pause Countdown Unit

This block holds one hardware thread in a stalled state for a requested number of clock cycles. Software writes a cycle count. The unit drops the low three bits of that count and loads the remaining quotient into a countdown register. A free-running three-bit prescaler then decrements that register once every eight clocks, so the stall length has a granularity of eight cycles.

A request of fewer than eight cycles, including zero, still stalls the thread for a single cycle. A disrupting trap ends a pause at once. The end of every pause is marked by a one-cycle completion pulse, whether the pause ran out or a trap ended it. A fresh write while a pause is running replaces the remaining count and restarts the prescaler phase.

Top module: `strand_pause_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit goes idle: `stall_o` and `done_o` are low in the following cycle, and they stay low until a write arrives.
- R2: A cycle with `wr_en` high makes `stall_o` high from the next cycle on.
- R3: For a written value V of 8 or more, `stall_o` stays high for exactly 8*(V>>3) consecutive cycles. The three low bits of V have no effect on the length.
- R4: For a written value below 8, zero included, `stall_o` is high for exactly one cycle.
- R5: `done_o` is a single-cycle pulse. It is high in the first cycle in which `stall_o` is low after a pause ends, whether by expiry or by trap, and it is never high at any other time.
- R6: `trap_in` high in a stalled cycle with no write makes `stall_o` low and `done_o` high in the next cycle.
- R7: `trap_in` while the unit is idle has no effect: `stall_o` and `done_o` stay low.
- R8: A write during a pause reloads the count and restarts the eight-cycle phase. From the cycle after that write, the stall lasts exactly as R3 or R4 gives for the new value, and no `done_o` pulse appears at the reload.
- R9: When `wr_en` and `trap_in` are high in the same cycle, the write takes precedence and a new pause starts.
- R10: A write in the last stalled cycle of a pause extends the stall without a gap and without a `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a pause request |
| wr_data | input | DATA_W | Requested stall length in cycles |
| trap_in | input | 1 | Disrupting trap; releases an active pause |
| stall_o | output | 1 | Thread is stalled (registered) |
| done_o | output | 1 | One-cycle pulse when a pause ends (registered) |

## Verification
A corrupted countdown value or prescaler phase shows up as `stall_o` falling early or late. The error is visible at the first release edge, which comes at most eight cycles per remaining count unit later. A wrong activity flag shows within one cycle as a stall that will not start, will not clear on a trap, or lingers while idle. It also shows as a missing or spurious `done_o` pulse. A behavioural model that counts the remaining stall cycles is compared with both outputs on every clock, so any of these faults is reported in the cycle where the port first differs.

// File: rtl/pause_pkg.sv
package pause_pkg;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_BUSY = 1'b1
  } pause_state_e;

endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int GRAN_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);

  logic [GRAN_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // Tick on the last phase of each granule
  assign tick = run && !restart && (phase_q == '1);

endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int DATA_W    = 16,
  parameter int GRAN_LOG2 = 3,
  localparam int CNT_W    = DATA_W - GRAN_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Zero count releases after one cycle; otherwise release on the final tick
  assign expire = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && tick);

endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic trap_in,
  input  logic expire,
  output logic busy,
  output logic stall_o,
  output logic done_o
);

  pause_state_e state_q;
  pause_state_e state_d;
  logic         done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (wr_en) begin
      state_d = PS_BUSY;
    end else if ((state_q == PS_BUSY) && (trap_in || expire)) begin
      state_d = PS_IDLE;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end

  assign busy    = (state_q == PS_BUSY);
  assign stall_o = busy;

endmodule

// File: rtl/strand_pause_unit.sv
module strand_pause_unit #(
  parameter int DATA_W    = 16,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap_in,
  output logic              stall_o,
  output logic              done_o
);

  localparam int CNT_W = DATA_W - GRAN_LOG2;

  logic             busy;
  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] load_val;

  assign load_val = wr_data[DATA_W-1:GRAN_LOG2];

  pause_prescaler #(
    .GRAN_LOG2(GRAN_LOG2)
  ) u_prescaler (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_en),
    .run     (busy),
    .tick    (tick)
  );

  pause_countdown #(
    .DATA_W   (DATA_W),
    .GRAN_LOG2(GRAN_LOG2)
  ) u_countdown (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_en),
    .load_val (load_val),
    .tick     (tick),
    .expire   (expire)
  );

  pause_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .trap_in (trap_in),
    .expire  (expire),
    .busy    (busy),
    .stall_o (stall_o),
    .done_o  (done_o)
  );

endmodule

// File: rtl/strand_pause_unit_checker.sv
module strand_pause_unit_checker #(
  parameter int DATA_W    = 16,
  parameter int GRAN_LOG2 = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              trap_in,
  input logic              stall_o,
  input logic              done_o
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!stall_o && !done_o));

  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (!stall_o && !wr_en) |=> !stall_o);

  assert_write_stalls_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> stall_o);

  assert_small_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((wr_data >> GRAN_LOG2) == '0)) ##1 !wr_en |=> !stall_o);

  assert_done_after_stall_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!stall_o && $past(stall_o)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_trap_release_R6: assert property (@(posedge clk) disable iff (rst)
    (stall_o && trap_in && !wr_en) |=> (!stall_o && done_o));

  assert_trap_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!stall_o && trap_in && !wr_en) |=> (!stall_o && !done_o));

  assert_write_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !done_o);

  assert_write_beats_trap_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && trap_in) |=> (stall_o && !done_o));

endmodule

bind strand_pause_unit strand_pause_unit_checker #(
  .DATA_W   (DATA_W),
  .GRAN_LOG2(GRAN_LOG2)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .trap_in (trap_in),
  .stall_o (stall_o),
  .done_o  (done_o)
);

// File: tb/strand_pause_unit_bench.sv
module strand_pause_unit_bench;

  localparam int DATA_W = 16;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              trap_in = 1'b0;
  logic              stall_o;
  logic              done_o;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    armed = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_stall = 1'b0;
  bit m_done  = 1'b0;
  int m_left  = 0;

  always #5 clk = ~clk;

  strand_pause_unit #(.DATA_W(DATA_W)) u_strand_pause_unit (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .trap_in (trap_in),
    .stall_o (stall_o),
    .done_o  (done_o)
  );

  // Behavioural model: remaining stall cycles as a plain integer
  always @(posedge clk) begin
    armed <= 1'b1;
    cycles <= cycles + 1;
    if (rst) begin
      m_stall = 1'b0;
      m_done  = 1'b0;
      m_left  = 0;
    end else if (wr_en) begin
      m_stall = 1'b1;
      m_done  = 1'b0;
      m_left  = ((int'(wr_data) / 8) == 0) ? 1 : 8 * (int'(wr_data) / 8);
    end else if (m_stall && trap_in) begin
      m_stall = 1'b0;
      m_done  = 1'b1;
      m_left  = 0;
    end else if (m_stall) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        m_stall = 1'b0;
        m_done  = 1'b1;
      end else begin
        m_done = 1'b0;
      end
    end else begin
      m_done = 1'b0;
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && !finished) begin
      total++;
      if (stall_o !== m_stall) begin
        bad++;
        $display("FAIL %s cycle %0d stall_o actual=%b expected=%b", cur_req, cycles, stall_o, m_stall);
      end
      total++;
      if (done_o !== m_done) begin
        bad++;
        $display("FAIL %s cycle %0d done_o actual=%b expected=%b", cur_req, cycles, done_o, m_done);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input int v, input bit with_trap);
    wr_en   = 1'b1;
    wr_data = DATA_W'(v);
    trap_in = with_trap;
    @(negedge clk);
    wr_en   = 1'b0;
    trap_in = 1'b0;
  endtask

  task automatic pulse_trap;
    trap_in = 1'b1;
    @(negedge clk);
    trap_in = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst = 1'b0;
    idle(4);

    cur_req = "R7";
    pulse_trap();
    idle(3);

    cur_req = "R2";
    do_write(8, 1'b0);
    idle(12);

    cur_req = "R3";
    do_write(15, 1'b0);
    idle(12);
    do_write(16, 1'b0);
    idle(20);
    do_write(43, 1'b0);
    idle(45);

    cur_req = "R4";
    do_write(0, 1'b0);
    idle(3);
    do_write(5, 1'b0);
    idle(3);
    do_write(7, 1'b0);
    idle(3);

    cur_req = "R5";
    do_write(1, 1'b0);
    do_write(2, 1'b0);
    idle(4);

    cur_req = "R6";
    do_write(64, 1'b0);
    idle(10);
    pulse_trap();
    idle(4);
    do_write(3, 1'b0);
    pulse_trap();
    idle(3);

    cur_req = "R8";
    do_write(40, 1'b0);
    idle(13);
    do_write(24, 1'b0);
    idle(5);
    do_write(6, 1'b0);
    idle(4);
    do_write(32, 1'b0);
    idle(3);
    do_write(17, 1'b0);
    idle(20);

    cur_req = "R9";
    do_write(16, 1'b1);
    idle(6);
    do_write(9, 1'b1);
    idle(12);

    cur_req = "R10";
    do_write(8, 1'b0);
    idle(7);
    do_write(16, 1'b0);
    idle(20);
    do_write(0, 1'b0);
    do_write(8, 1'b0);
    idle(12);

    cur_req = "R1";
    do_write(200, 1'b0);
    idle(5);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    pulse_trap();
    idle(5);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule